// File: doc/BRIEF.md
# Byte-Wide SPI Transceiver with Selectable Role

This block moves one byte at a time over a four-wire serial link. A single control byte picks the role (clock-driving master or clock-following slave), the bit order, the idle clock level, the clock phase, the clock source and a divide ratio. Software starts a master exchange by writing a data byte. In slave mode a byte written while the link is idle is queued for return on the slave output line. Either way, the byte gathered from the partner is latched into a read buffer and a completion flag is raised. The flag stays set until it is cleared with a pulse.

Every serial line has a separate value output and drive-enable output, so surrounding pad logic can build push-pull, open-drain or pulled-up released pins. As master, the block generates the serial clock by dividing either the system clock or an external timer-overflow tick. It drives the data-out line only while a byte is moving. As slave, it resynchronises the incoming clock, select and data lines, follows edges in the system clock domain, and drives its data line only while selected and not muted.

The transfer engine is one state machine. Its states are:
- ST_IDLE: no transfer.
- ST_MPRIME: one cycle that places the first master bit.
- ST_MLEAD: the master clock sits at its idle level.
- ST_MTRAIL: the master clock sits at its active level.
- ST_SACTIVE: a slave byte is in progress.
- ST_SHOLD: the slave byte is finished and the block waits for deselect.

Its transitions are:
- ST_IDLE to ST_MPRIME on a data write in master mode.
- ST_MPRIME to ST_MLEAD after one cycle.
- ST_MLEAD to ST_MTRAIL at the end of each half period.
- ST_MTRAIL to ST_MLEAD at the end of a half period while bits remain.
- ST_MTRAIL to ST_IDLE after the eighth bit.
- ST_IDLE to ST_SACTIVE when select falls in slave mode.
- ST_SACTIVE to ST_SHOLD on the eighth sample.
- ST_SACTIVE to ST_IDLE when select rises mid-byte (abort).
- ST_SHOLD to ST_IDLE when select rises.
- Any state to ST_IDLE when the enable bit is cleared.

Top module: `spi_xcvr`

## Requirements
- R1: After reset the control byte is zero, all three drive enables are low, the completion flag is low and the read buffer is zero.
- R2: The control byte fields are: bit 7 timer-tick clock source, bit 6 enable, bit 5 LSB first, bit 4 master, bit 3 clock idle level (CPOL), bit 2 clock phase (CPHA), bits 1:0 divide select.
- R3: Divide select 0, 1, 2 and 3 gives a clock period of 4, 16, 64 and 128 source events. Each clock half lasts 2, 8, 32 or 64 source events. A source event is every system clock when bit 7 is 0, and each timer tick when bit 7 is 1.
- R4: Writing the control byte with the enable bit clear releases the clock, data-out and slave-out lines at once and abandons any transfer without setting the flag.
- R5: In master mode the clock line is driven, rests at the CPOL level between transfers, and makes exactly 16 transitions per byte.
- R6: The master data-out line is driven only while a byte is in progress and is released once the byte completes.
- R7: The slave data line is driven only in enabled slave mode with select low and the mute input low.
- R8: With LSB first set, bit 0 travels first; otherwise bit 7 travels first, in both directions.
- R9: In all four CPOL/CPHA combinations and both roles, the byte sent by the partner is received intact. With CPHA 0 data is sampled on leading clock edges and changes on trailing edges. With CPHA 1 data changes on leading edges and is sampled on trailing edges.
- R10: After the eighth bit the received byte appears in the read buffer and the flag rises. The flag falls only on a clear pulse.
- R11: Select rising during a slave byte aborts it without setting the flag, and the next byte is counted from its first bit.
- R12: A data write while a master byte is in progress is ignored.
- R13: A byte written in idle slave mode is shifted out on the slave data line during the next selected transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte value |
| miso_off | input | 1 | Forces the slave data output off |
| dat_wr | input | 1 | Data byte write strobe |
| dat_wdata | input | DATA_W | Data byte value |
| tmr_tick | input | 1 | Timer overflow tick, one cycle wide |
| done_clr | input | 1 | Clears the completion flag |
| done | output | 1 | Completion flag |
| rx_byte | output | DATA_W | Read buffer |
| sck_i | input | 1 | Serial clock from pad |
| sck_o | output | 1 | Serial clock value to pad |
| sck_oe | output | 1 | Serial clock drive enable |
| ss_n_i | input | 1 | Slave select from pad, active low |
| mosi_i | input | 1 | Master-out line from pad |
| mosi_o | output | 1 | Master-out value to pad |
| mosi_oe | output | 1 | Master-out drive enable |
| miso_i | input | 1 | Slave-out line from pad |
| miso_o | output | 1 | Slave-out value to pad |
| miso_oe | output | 1 | Slave-out drive enable |

## Verification
The assertions check, on every cycle, the drive-enable rules:
- the data-out line is driven only alongside a driven clock, and it was driven up to completion;
- the slave line is muted and never driven in master mode;
- all lines are released right after a disabling write;
- the master clock is quiet outside transfers;
- the flag falls only after a clear pulse.

Bit order, phase handling, divider ratios for both clock sources, the slave abort, and the ignored mid-transfer write can only be shown by the bench's sweeps. In those sweeps the bench plays the partner device, and the exchanged bytes and measured clock half periods are compared with arithmetic expectations.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;

    typedef struct packed {
        logic       tmr_src;
        logic       enable;
        logic       lsb_first;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] div_sel;
    } ctl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MPRIME,
        ST_MLEAD,
        ST_MTRAIL,
        ST_SACTIVE,
        ST_SHOLD
    } xfer_st_t;

    localparam int unsigned DIV_CNT_W = 6;

    // Last count of one clock half: half period minus one source event.
    function automatic logic [DIV_CNT_W-1:0] half_limit(input logic [1:0] sel);
        logic [DIV_CNT_W:0] half;
        half = (sel == 2'd3) ? (DIV_CNT_W+1)'(64) : (DIV_CNT_W+1)'(2 << (2 * sel));
        return DIV_CNT_W'(half - 1'b1);
    endfunction

endpackage

// File: rtl/spi_xcvr_sync.sv
module spi_xcvr_sync #(
    parameter int WIDTH = 1,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_xcvr_clkdiv.sv
module spi_xcvr_clkdiv
    import spi_xcvr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       use_tick,
    input  logic       tick,
    input  logic [1:0] sel,
    output logic       half_done
);
    logic [DIV_CNT_W-1:0] cnt;
    logic [DIV_CNT_W-1:0] lim;
    logic                 src_ev;

    assign src_ev    = use_tick ? tick : 1'b1;
    assign lim       = half_limit(sel);
    assign half_done = run && src_ev && (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (!run)   cnt <= '0;
        else if (src_ev) cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/spi_xcvr_shift.sv
module spi_xcvr_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lsb_first,
    input  logic         cpha,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         prime,
    input  logic         launch,
    input  logic         sample,
    input  logic         sin,
    output logic         out_bit,
    output logic [W-1:0] rx_q,
    output logic [W-1:0] rx_nx
);
    logic [W-1:0] tx_q;
    logic [W-1:0] tx_shf;
    logic         tx_pick;

    assign tx_pick = lsb_first ? tx_q[0] : tx_q[W-1];
    assign tx_shf  = lsb_first ? {1'b0, tx_q[W-1:1]} : {tx_q[W-2:0], 1'b0};
    assign rx_nx   = lsb_first ? {sin, rx_q[W-1:1]} : {rx_q[W-2:0], sin};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q    <= '0;
            out_bit <= 1'b0;
            rx_q    <= '0;
        end else begin
            if (wr) begin
                tx_q <= wdata;
            end else if (prime) begin
                out_bit <= tx_pick;
                if (!cpha) tx_q <= tx_shf;
            end else if (launch) begin
                out_bit <= tx_pick;
                tx_q    <= tx_shf;
            end
            if (sample) rx_q <= rx_nx;
        end
    end
endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
    import spi_xcvr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_wdata,
    input  logic              miso_off,
    input  logic              dat_wr,
    input  logic [DATA_W-1:0] dat_wdata,
    input  logic              tmr_tick,
    input  logic              done_clr,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              ss_n_i,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe
);
    localparam int CNT_W = $clog2(DATA_W);

    ctl_t              ctl_q;
    xfer_st_t          st, st_nx;
    logic [CNT_W-1:0]  bit_cnt;
    logic              last_bit;
    logic              sck_s, ss_s, mosi_s, sck_d;
    logic              s_lead, s_trail, half_done, run_div;
    logic              ev_lead, ev_trail, sample, launch, prime, wr_tx;
    logic              m_active, finish, out_bit, sin;
    logic [DATA_W-1:0] rx_q, rx_nx;

    spi_xcvr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({sck_i, ss_n_i, mosi_i}), .q({sck_s, ss_s, mosi_s})
    );

    assign run_div = (st == ST_MLEAD) || (st == ST_MTRAIL);

    spi_xcvr_clkdiv u_div (
        .clk(clk), .rst_n(rst_n), .run(run_div), .use_tick(ctl_q.tmr_src),
        .tick(tmr_tick), .sel(ctl_q.div_sel), .half_done(half_done)
    );

    // Slave-side edge classification in the system clock domain.
    assign s_lead   = (sck_s != sck_d) && (sck_s != ctl_q.cpol);
    assign s_trail  = (sck_s != sck_d) && (sck_s == ctl_q.cpol);
    assign last_bit = (bit_cnt == CNT_W'(DATA_W - 1));
    assign m_active = (st == ST_MLEAD) || (st == ST_MTRAIL) || (st == ST_MPRIME);
    assign ev_lead  = ((st == ST_MLEAD) && half_done) || ((st == ST_SACTIVE) && s_lead);
    assign ev_trail = ((st == ST_MTRAIL) && half_done) || ((st == ST_SACTIVE) && s_trail);
    assign sample   = ctl_q.cpha ? ev_trail : ev_lead;
    assign launch   = ctl_q.cpha ? ev_lead : ev_trail;
    assign wr_tx    = dat_wr && ctl_q.enable && (st == ST_IDLE);
    assign prime    = (st == ST_MPRIME) ||
                      ((st == ST_IDLE) && ctl_q.enable && !ctl_q.master && !ss_s);
    assign finish   = ((st == ST_MTRAIL) && half_done && last_bit) ||
                      ((st == ST_SACTIVE) && sample && last_bit);
    assign sin      = ctl_q.master ? miso_i : mosi_s;

    spi_xcvr_shift #(.W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .lsb_first(ctl_q.lsb_first), .cpha(ctl_q.cpha),
        .wr(wr_tx), .wdata(dat_wdata), .prime(prime), .launch(launch),
        .sample(sample), .sin(sin), .out_bit(out_bit), .rx_q(rx_q), .rx_nx(rx_nx)
    );

    // Next-state logic.
    always_comb begin
        st_nx = st;
        if (!ctl_q.enable) begin
            st_nx = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:    if (ctl_q.master && dat_wr)        st_nx = ST_MPRIME;
                            else if (!ctl_q.master && !ss_s)   st_nx = ST_SACTIVE;
                ST_MPRIME:                                     st_nx = ST_MLEAD;
                ST_MLEAD:   if (half_done)                     st_nx = ST_MTRAIL;
                ST_MTRAIL:  if (half_done)                     st_nx = last_bit ? ST_IDLE : ST_MLEAD;
                ST_SACTIVE: if (ss_s)                          st_nx = ST_IDLE;
                            else if (sample && last_bit)       st_nx = ST_SHOLD;
                ST_SHOLD:   if (ss_s)                          st_nx = ST_IDLE;
                default:                                       st_nx = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Control byte, bit counter, completion flag and read buffer.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            bit_cnt <= '0;
            done    <= 1'b0;
            rx_byte <= '0;
            sck_d   <= 1'b0;
        end else begin
            sck_d <= sck_s;
            if (ctl_wr) ctl_q <= ctl_t'(ctl_wdata);
            if (st == ST_IDLE)
                bit_cnt <= '0;
            else if (((st == ST_MTRAIL) && half_done) || ((st == ST_SACTIVE) && sample))
                bit_cnt <= bit_cnt + 1'b1;
            if (finish && ctl_q.enable) begin
                done    <= 1'b1;
                rx_byte <= sample ? rx_nx : rx_q;
            end else if (done_clr) begin
                done <= 1'b0;
            end
        end
    end

    // Pad-facing outputs.
    always_comb begin
        sck_oe  = ctl_q.enable && ctl_q.master;
        sck_o   = ctl_q.cpol ^ (st == ST_MTRAIL);
        mosi_oe = ctl_q.enable && ctl_q.master && m_active && (st != ST_MPRIME);
        mosi_o  = out_bit;
        miso_oe = ctl_q.enable && !ctl_q.master && !ss_s && !miso_off;
        miso_o  = out_bit;
    end
endmodule

// File: rtl/spi_xcvr_chk.sv
module spi_xcvr_chk (
    input logic clk,
    input logic rst_n,
    input logic ctl_wr,
    input logic ctl_en_bit,
    input logic miso_off,
    input logic done_clr,
    input logic done,
    input logic sck_o,
    input logic sck_oe,
    input logic mosi_oe,
    input logic miso_oe
);
    a_r4_disable_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_en_bit) |=> (!sck_oe && !mosi_oe && !miso_oe));

    a_r6_mosi_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
        mosi_oe |-> sck_oe);

    a_r6_mosi_driven_to_end: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && sck_oe && !$past(ctl_wr)) |-> $past(mosi_oe));

    a_r7_miso_gate: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> (!sck_oe && !miso_off));

    a_r5_sck_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_oe && !mosi_oe && !$past(mosi_oe) && !$past(ctl_wr)) |-> $stable(sck_o));

    a_r10_done_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past(done_clr));
endmodule

bind spi_xcvr spi_xcvr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_en_bit(ctl_wdata[6]),
    .miso_off(miso_off), .done_clr(done_clr), .done(done), .sck_o(sck_o),
    .sck_oe(sck_oe), .mosi_oe(mosi_oe), .miso_oe(miso_oe)
);

// File: tb/spi_xcvr_bench.sv
`timescale 1ns/1ps
module spi_xcvr_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       miso_off = 1'b0;
    logic       dat_wr = 1'b0;
    logic [7:0] dat_wdata = '0;
    logic       tmr_tick = 1'b0;
    logic       done_clr = 1'b0;
    logic       done;
    logic [7:0] rx_byte;
    logic       sck_i = 1'b0, sck_o, sck_oe;
    logic       ss_n_i = 1'b1;
    logic       mosi_i = 1'b0, mosi_o, mosi_oe;
    logic       miso_i = 1'b0, miso_o, miso_oe;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         finished = 1'b0;

    always #2 clk = ~clk;

    spi_xcvr u_spi_xcvr (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .miso_off(miso_off), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
        .tmr_tick(tmr_tick), .done_clr(done_clr), .done(done), .rx_byte(rx_byte),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .ss_n_i(ss_n_i),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe)
    );

    // Timer tick: one pulse every 3 system clocks.
    initial begin
        int tc = 0;
        forever begin
            @(negedge clk);
            tc = (tc + 1) % 3;
            tmr_tick = (tc == 0);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic clr_done();
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
    endtask

    function automatic int pos(input bit lsb, input int i);
        return lsb ? i : 7 - i;
    endfunction

    // Bench acts as the slave partner of a master-mode transfer.
    task automatic master_xfer(input logic [7:0] ctl, input logic [7:0] txb,
                               input logic [7:0] slvb, input bit busy_wr, input int exp_half);
        bit cpha = ctl[2], cpol = ctl[3], lsb = ctl[5];
        logic [7:0] got = '0;
        int tog = 0, idx = 0, cyc = 0, t1 = 0, t2 = 0;
        logic prev;
        wr_ctl(ctl);
        chk(sck_oe && sck_o == cpol && !mosi_oe, "R5 idle clock level", int'(sck_o), int'(cpol));
        miso_i = cpha ? 1'b0 : slvb[pos(lsb, 0)];
        @(negedge clk); dat_wr = 1'b1; dat_wdata = txb;
        @(negedge clk); dat_wr = 1'b0;
        prev = cpol;
        while (!done && cyc < 4000) begin
            @(negedge clk);
            dat_wr = 1'b0;
            cyc++;
            if (sck_o != prev) begin
                prev = sck_o;
                tog++;
                if (tog == 1) begin
                    t1 = cyc;
                    chk(mosi_oe, "R6 mosi driven in transfer", int'(mosi_oe), 1);
                end
                if (tog == 2) t2 = cyc;
                if (sck_o != cpol) begin
                    if (!cpha) got[pos(lsb, idx)] = mosi_o;
                    else       miso_i = slvb[pos(lsb, idx)];
                end else begin
                    if (cpha) got[pos(lsb, idx)] = mosi_o;
                    idx++;
                    if (!cpha && idx < 8) miso_i = slvb[pos(lsb, idx)];
                end
                if (busy_wr && tog == 3) begin
                    dat_wr = 1'b1; dat_wdata = ~txb;
                end
            end
        end
        chk(tog == 16, "R5 sixteen clock transitions", tog, 16);
        chk(got == txb, busy_wr ? "R12 busy write ignored" : "R8 R9 mosi byte", int'(got), int'(txb));
        chk(rx_byte == slvb, "R9 R10 received byte", int'(rx_byte), int'(slvb));
        chk(done, "R10 flag set", int'(done), 1);
        chk(!mosi_oe && sck_o == cpol, "R6 mosi released after byte", int'(mosi_oe), 0);
        if (exp_half > 0) chk(t2 - t1 == exp_half, "R3 half period", t2 - t1, exp_half);
        idle(3);
        chk(done, "R10 flag holds", int'(done), 1);
        clr_done();
        chk(!done, "R10 flag cleared", int'(done), 0);
    endtask

    // Bench acts as the master partner of a slave-mode transfer.
    task automatic slave_xfer(input logic [7:0] ctl, input logic [7:0] stx,
                              input logic [7:0] mtx, input int abort_at);
        bit cpha = ctl[2], cpol = ctl[3], lsb = ctl[5];
        logic [7:0] got = '0;
        wr_ctl(ctl);
        ss_n_i = 1'b1; sck_i = cpol; mosi_i = 1'b0;
        idle(6);
        @(negedge clk); dat_wr = 1'b1; dat_wdata = stx;
        @(negedge clk); dat_wr = 1'b0;
        ss_n_i = 1'b0;
        if (!cpha) mosi_i = mtx[pos(lsb, 0)];
        idle(8);
        chk(miso_oe, "R7 miso driven when selected", int'(miso_oe), 1);
        for (int i = 0; i < 8; i++) begin
            if (i == abort_at) break;
            if (!cpha) begin
                got[pos(lsb, i)] = miso_o;
                sck_i = ~cpol; idle(8);
                sck_i = cpol;
                if (i < 7) mosi_i = mtx[pos(lsb, i + 1)];
                idle(8);
            end else begin
                sck_i = ~cpol; mosi_i = mtx[pos(lsb, i)]; idle(8);
                got[pos(lsb, i)] = miso_o;
                sck_i = cpol; idle(8);
            end
        end
        ss_n_i = 1'b1;
        idle(8);
        chk(!miso_oe, "R7 miso released on deselect", int'(miso_oe), 0);
        if (abort_at < 8) begin
            chk(!done, "R11 abort leaves flag low", int'(done), 0);
        end else begin
            chk(done, "R10 slave flag set", int'(done), 1);
            chk(rx_byte == mtx, "R8 R9 slave received byte", int'(rx_byte), int'(mtx));
            chk(got == stx, "R13 slave returned byte", int'(got), int'(stx));
            clr_done();
        end
    endtask

    initial begin
        idle(4);
        chk(!sck_oe && !mosi_oe && !miso_oe, "R1 enables low in reset", int'({sck_oe, mosi_oe, miso_oe}), 0);
        rst_n = 1'b1;
        ss_n_i = 1'b0;
        idle(5);
        chk(!sck_oe && !mosi_oe && !miso_oe, "R1 enables low after reset", int'({sck_oe, mosi_oe, miso_oe}), 0);
        chk(!done && rx_byte == 8'h00, "R1 flag and buffer clear", int'(rx_byte), 0);
        ss_n_i = 1'b1;

        // R2 R8 R9: master sweep over all modes and both bit orders.
        for (int m = 0; m < 4; m++) begin
            for (int l = 0; l < 2; l++) begin
                logic [7:0] c;
                c = 8'h50 | 8'(l << 5) | 8'(m << 2);
                master_xfer(c, 8'hA5 ^ 8'(m * 17 + l), 8'h3C ^ 8'(m * 5 + l * 64), 1'b0, 2);
                master_xfer(c, 8'h01 << (m + l), 8'h80 >> (m * 2 + l), 1'b0, 2);
            end
        end

        // R3: divider ratios from system clock, then from the timer tick.
        for (int s = 0; s < 4; s++) begin
            int h;
            h = (s == 3) ? 64 : (2 << (2 * s));
            master_xfer(8'h50 | 8'(s), 8'hC3, 8'h5A, 1'b0, h);
        end
        for (int s = 0; s < 2; s++) begin
            int h;
            h = (2 << (2 * s)) * 3;
            master_xfer(8'hD0 | 8'(s), 8'h69, 8'h96, 1'b0, h);
        end

        // R12: write during a master byte.
        master_xfer(8'h5C, 8'h96, 8'h69, 1'b1, 2);

        // R4: disable in mid-transfer.
        wr_ctl(8'h53);
        @(negedge clk); dat_wr = 1'b1; dat_wdata = 8'hFF;
        @(negedge clk); dat_wr = 1'b0;
        idle(40);
        wr_ctl(8'h13);
        chk(!sck_oe && !mosi_oe && !miso_oe, "R4 disable releases lines", int'({sck_oe, mosi_oe, miso_oe}), 0);
        idle(1200);
        chk(!done, "R4 abandoned byte sets no flag", int'(done), 0);

        // R9 R13: slave sweep.
        for (int m = 0; m < 4; m++) begin
            for (int l = 0; l < 2; l++) begin
                slave_xfer(8'h40 | 8'(l << 5) | 8'(m << 2),
                           8'hC6 ^ 8'(m * 33 + l), 8'h2B ^ 8'(m * 9 + l * 128), 8);
            end
        end

        // R11: deselect after three bits, then a full byte.
        slave_xfer(8'h40, 8'h11, 8'hF0, 3);
        slave_xfer(8'h40, 8'h81, 8'h7E, 8);
        slave_xfer(8'h44, 8'h0F, 8'hE1, 5);
        slave_xfer(8'h44, 8'hE7, 8'h18, 8);

        // R7: mute input and master mode keep the slave line released.
        wr_ctl(8'h40);
        ss_n_i = 1'b0; miso_off = 1'b1;
        idle(6);
        chk(!miso_oe, "R7 mute forces miso off", int'(miso_oe), 0);
        miso_off = 1'b0;
        idle(1);
        chk(miso_oe, "R7 miso back on", int'(miso_oe), 1);
        wr_ctl(8'h50);
        chk(!miso_oe, "R7 no miso drive in master", int'(miso_oe), 0);
        ss_n_i = 1'b1;
        idle(6);

        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            finish_run();
        end
    end
endmodule